// File: doc/BRIEF.md
# Fetch Redirect and Squash Control

This block decides where the next instruction fetch comes from in a five-stage in-order pipeline. It also decides which already-fetched instructions are thrown away by turning them into bubbles. Fetch always guesses the sequential address. Unconditional jumps are recognised in decode, so one wrong-path instruction has already been fetched by then. Conditional branches on a register being zero or non-zero are resolved in execute, so two wrong-path instructions have been fetched by then.

The block is purely combinational. It reads the decode-stage and execute-stage opcodes, the execute-stage zero flag and the raw interlock request from the hazard logic. It drives the PC source select, a bubble request for the decode instruction register, a bubble request for the execute instruction register, and a qualified stall. The qualified stall holds the PC and the decode register. Target address arithmetic lives outside this block.

Where decisions conflict, the older instruction wins. A taken branch in execute overrides any decision derived from decode, and it cancels the interlock, because the instruction sitting in decode is on the wrong path.

Top module: `fetch_redirect_ctl`

## Requirements
- R1: Opcode codes (4 bits) are: 0 nop, 2 J, 3 JAL, 4 JR, 5 JALR, 6 BEQZ, 7 BNEZ; every other code is a non-control instruction. A taken branch is execute opcode 6 with `ex_zero`=1, or execute opcode 7 with `ex_zero`=0. On a taken branch, `pc_sel` is 3 (branch target), whatever decode holds.
- R2: With no taken branch and no qualified stall, `pc_sel` is 1 (absolute target) for decode opcode 2 or 3, 2 (register-indirect target) for decode opcode 4 or 5, and 0 (sequential PC+4) otherwise.
- R3: `dec_nop` is 1 on a taken branch. It is also 1 when decode holds opcode 2..5 and `stall_q` is 0. Otherwise it is 0, and decode loads from instruction memory.
- R4: `ex_nop` is 1 on a taken branch or when `stall_q` is 1. Otherwise it is 0, and execute takes the decode instruction.
- R5: `stall_q` equals `raw_stall` except on a taken branch, when it is 0.
- R6: While `stall_q` is 1, `pc_sel` is 0 and `dec_nop` is 0. A jump held in decode redirects only once the stall clears.
- R7: Execute opcodes other than 6 and 7, including nop, cause no redirect and no squash. Decode opcodes outside 2..5, including nop, cause no redirect.
- R8: In a running pipeline, a jump squashes exactly the one instruction fetched after it. A taken branch squashes exactly the two instructions fetched after it. A not-taken branch squashes nothing. A branch entering execute right after an interlock bubble still behaves by R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only to sample the checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| dec_op | input | 4 | Opcode of the instruction in decode |
| ex_op | input | 4 | Opcode of the instruction in execute |
| ex_zero | input | 1 | Execute-stage register equals zero |
| raw_stall | input | 1 | Interlock request from the hazard logic |
| pc_sel | output | 2 | 0 PC+4, 1 absolute, 2 register-indirect, 3 branch target |
| dec_nop | output | 1 | Load a bubble into the decode register |
| ex_nop | output | 1 | Load a bubble into the execute register |
| stall_q | output | 1 | Qualified stall: hold PC and decode register |

## Verification
The embedded properties check the single-cycle relations on every cycle:
- a taken branch forces the branch-target select, both bubbles and no stall;
- the qualified stall never appears without a raw request, and always comes with an execute bubble;
- an unstalled decode jump always squashes.

Only the bench's pipeline run can show that these per-cycle choices, applied to real PC and instruction registers, squash exactly one or two wrong-path instructions. The same run shows that a branch behind an interlock bubble resolves correctly and that the wrong-path addresses never reach execute.

// File: rtl/fetch_redirect_ctl.sv
module fetch_redirect_ctl #(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] dec_op,
  input  logic [OPW-1:0] ex_op,
  input  logic           ex_zero,
  input  logic           raw_stall,
  output logic [1:0]     pc_sel,
  output logic           dec_nop,
  output logic           ex_nop,
  output logic           stall_q
);
  localparam logic [OPW-1:0] OP_J    = OPW'(2);
  localparam logic [OPW-1:0] OP_JAL  = OPW'(3);
  localparam logic [OPW-1:0] OP_JR   = OPW'(4);
  localparam logic [OPW-1:0] OP_JALR = OPW'(5);
  localparam logic [OPW-1:0] OP_BEQZ = OPW'(6);
  localparam logic [OPW-1:0] OP_BNEZ = OPW'(7);

  localparam logic [1:0] SEL_SEQ = 2'd0;
  localparam logic [1:0] SEL_ABS = 2'd1;
  localparam logic [1:0] SEL_IND = 2'd2;
  localparam logic [1:0] SEL_BR  = 2'd3;

  logic br_taken, jmp_abs, jmp_ind, jmp_any;

  assign br_taken = (ex_op == OP_BEQZ && ex_zero) || (ex_op == OP_BNEZ && !ex_zero);
  assign jmp_abs  = (dec_op == OP_J)  || (dec_op == OP_JAL);
  assign jmp_ind  = (dec_op == OP_JR) || (dec_op == OP_JALR);
  assign jmp_any  = jmp_abs || jmp_ind;

  assign stall_q  = raw_stall && !br_taken;

  always_comb begin
    if (br_taken)             pc_sel = SEL_BR;
    else if (stall_q)         pc_sel = SEL_SEQ;
    else if (jmp_abs)         pc_sel = SEL_ABS;
    else if (jmp_ind)         pc_sel = SEL_IND;
    else                      pc_sel = SEL_SEQ;
  end

  assign dec_nop = br_taken || (jmp_any && !stall_q);
  assign ex_nop  = br_taken || stall_q;

  // R1 R3 R4 R5
  taken_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (pc_sel == SEL_BR && dec_nop && ex_nop && !stall_q));

  // R5
  stall_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> raw_stall);

  // R4
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> (ex_nop && pc_sel == SEL_SEQ && !dec_nop));

  // R3
  jump_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_any && !stall_q) |-> dec_nop);

  // R7
  no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_taken && !jmp_any) |-> (pc_sel == SEL_SEQ && !dec_nop));
endmodule

// File: tb/test_fetch_redirect_ctl.sv
module test_fetch_redirect_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dec_op = '0, ex_op = '0;
  logic       ex_zero = 1'b0, raw_stall = 1'b0;
  logic [1:0] pc_sel;
  logic       dec_nop, ex_nop, stall_q;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  fetch_redirect_ctl i_fetch_redirect_ctl (
    .clk(clk), .rst_n(rst_n), .dec_op(dec_op), .ex_op(ex_op),
    .ex_zero(ex_zero), .raw_stall(raw_stall), .pc_sel(pc_sel),
    .dec_nop(dec_nop), .ex_nop(ex_nop), .stall_q(stall_q));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (dec=%0d ex=%0d z=%0d st=%0d)",
               req, act, exp, dec_op, ex_op, ex_zero, raw_stall);
    end
  endtask

  function automatic logic [3:0] prog(input int a);
    case (a)
      'h04: return 4'd2;
      'h80: return 4'd8;
      'h84: return 4'd9;
      'h88: return 4'd6;
      'h60: return 4'd7;
      'h68: return 4'd4;
      default: return 4'd1;
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int pc, d_pc, e_pc, nret;
    logic [3:0] d_op_s, e_op_s;
    int ret [16];
    int exp_ret [10];
    exp_ret = '{'h00, 'h04, 'h80, 'h84, 'h88, 'h60, 'h64, 'h68, 'hC0, 'hC4};

    repeat (3) @(negedge clk);
    check("reset R7 pc_sel", pc_sel, 0);
    check("reset R3 dec_nop", dec_nop, 0);
    check("reset R4 ex_nop", ex_nop, 0);
    check("reset R5 stall_q", stall_q, 0);
    rst_n = 1'b1;

    for (int d = 0; d < 16; d++)
      for (int e = 0; e < 16; e++)
        for (int z = 0; z < 2; z++)
          for (int s = 0; s < 2; s++) begin
            bit tk, ja, ji, sq;
            int ep;
            @(negedge clk);
            dec_op = 4'(d); ex_op = 4'(e); ex_zero = z[0]; raw_stall = s[0];
            #1;
            tk = (e == 6 && z == 1) || (e == 7 && z == 0);
            ja = (d == 2 || d == 3);
            ji = (d == 4 || d == 5);
            sq = s[0] && !tk;
            ep = tk ? 3 : sq ? 0 : ja ? 1 : ji ? 2 : 0;
            if (tk) check("R1 pc_sel", pc_sel, ep);
            else if (sq) check("R6 pc_sel", pc_sel, ep);
            else if (ja || ji) check("R2 pc_sel", pc_sel, ep);
            else check("R7 pc_sel", pc_sel, ep);
            check("R3 dec_nop", dec_nop, int'(tk || ((ja || ji) && !sq)));
            check("R4 ex_nop", ex_nop, int'(tk || sq));
            check("R5 stall_q", stall_q, int'(sq));
          end

    pc = 0; d_pc = -1; e_pc = -1; d_op_s = 0; e_op_s = 0; nret = 0;
    ex_zero = 1'b1;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      dec_op = d_op_s; ex_op = e_op_s;
      raw_stall = (d_op_s == 4'd9 && e_op_s == 4'd8);
      #1;
      if (e_op_s != 0 && nret < 16) begin ret[nret] = e_pc; nret++; end
      if (ex_nop) begin e_op_s = 0; e_pc = -1; end
      else begin e_op_s = d_op_s; e_pc = d_pc; end
      if (!stall_q) begin
        if (dec_nop) begin d_op_s = 0; d_pc = -1; end
        else begin d_op_s = prog(pc); d_pc = pc; end
        case (pc_sel)
          2'd1: pc = 'h80;
          2'd2: pc = 'hC0;
          2'd3: pc = 'h60;
          default: pc = pc + 4;
        endcase
      end
    end
    check("R8 retired count", int'(nret >= 10), 1);
    for (int k = 0; k < 10; k++)
      check($sformatf("R8 retired[%0d]", k), ret[k], exp_ret[k]);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule